// File: doc/BRIEF.md
# Reset Stretcher and Bootstrap Latch

This block sits between the chip's active-low reset pin and the rest of the core. A two-stage synchroniser brings the pin into the input-clock domain. Once the synchronised release arrives, a counter holds the internal reset low for a fixed 512 input-clock cycles. When the pin goes low, every reset-dependent output returns to its reset state at once, with no clock edge needed.

While the internal reset is asserted, the core runs on a clock enable that fires once every eight input-clock cycles. After release it fires on every cycle. On the first clock edge that sees the pin high, the block captures four configuration straps from the host data bus. The block also drives the output-enable and level controls for each group of pins. Two clock outputs float and a third is held low until six slow core periods after release. The memory bus group and the serial pin groups float, and the bus-request output is marked invalid, until the internal reset ends. A PLL-bypass flag stays set through reset and after it, until the PLL control logic asks to clear it.

Top module: `rsb_top`

## Requirements
- R1: `intRstN` is 0 while `extRstN` is 0. Counting the first rising `clkIn` edge that samples `extRstN` high as edge 1, `intRstN` is still 0 after edge 513 and becomes 1 after edge 514 (2 synchroniser stages plus 512 stretch cycles).
- R2: While `intRstN` is 0, `coreClkEn` is high for exactly one cycle in every 8. After release it is high after edges 7, 15, 23 and so on. It stays 0 while `extRstN` is 0, and it is 1 on every cycle once `intRstN` is 1.
- R3: At edge 1 the block loads `bootCfg`: bit 3 from `hostData[14]`, bit 2 from `hostData[8]`, bit 1 from `hostData[4]` and bit 0 from `hostData[3]`. Later changes on `hostData` do not alter `bootCfg` until the next reset.
- R4: `bootCfg` reads 0 while `extRstN` is 0.
- R5: Until the clocks are valid, `clkZOe` is 0 (two clock outputs float) and `clkLowHold` is 1 (third clock driven low). Both change (`clkZOe`=1, `clkLowHold`=0) after edge 48, which is six core periods of 8 cycles after release.
- R6: `memBusOe`, every bit of `serialOe` and `busReqValid` are 0 while `intRstN` is 0, and all are 1 while `intRstN` is 1.
- R7: `pllBypass` is 1 during reset and remains 1 after release. A `bypassClr` pulse while `intRstN` is 1 clears it at the next edge. `bypassClr` is ignored while `intRstN` is 0.
- R8: If `extRstN` falls again before the stretch ends, the count restarts from zero. The next release redoes the capture and runs the full 514-edge sequence.
- R9: A falling `extRstN` forces `intRstN`=0, all pin-group enables to 0, `clkLowHold`=1 and `pllBypass`=1 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input reference clock |
| extRstN | input | 1 | External active-low reset pin |
| hostData | input | 16 | Host data bus carrying the configuration straps |
| bypassClr | input | 1 | Request from PLL control logic to leave bypass |
| intRstN | output | 1 | Stretched internal active-low reset |
| coreClkEn | output | 1 | Core clock enable (1-in-8 during reset) |
| bootCfg | output | 4 | Captured configuration straps |
| pllBypass | output | 1 | PLL bypass select |
| clkZOe | output | 1 | Output enable for the two floating clock outputs |
| clkLowHold | output | 1 | Forces the third clock output low |
| memBusOe | output | 1 | Output enable for the memory bus group |
| serialOe | output | 2 | Output enables for the two serial pin groups |
| busReqValid | output | 1 | Bus-request output valid |

## Verification
The hardest situation to reach is a reset pin that drops again partway through the 512-cycle stretch, including on the very last cycle before release. The stimulus aborts releases at fixed and random points, then follows each abort with a full release that uses fresh strap data. Each full run checks both the capture and the exact release edge. The straps are changed a few cycles after capture, so a register that keeps sampling would show up as wrong.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int BOOT_W = 4;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;  // load straps on this edge
    logic syncRel;  // synchronised pin release seen
    logic inRst;    // internal reset still asserted
  } rsbStrobe_t;

  // Host bus bit feeding each strap position
  function automatic int bootPos(input int idx);
    case (idx)
      0:       return 3;
      1:       return 4;
      2:       return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
#(
  parameter int STRETCH     = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkIn,
  input  logic       extRstN,
  output rsbStrobe_t strb,
  output logic       intRstN
);

  localparam int CNT_W = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       stretchCnt;
  logic                   stretchDone;

  // Assert asynchronously, release through the synchroniser
  always_ff @(posedge clkIn or negedge extRstN) begin
    if (!extRstN) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clkIn or negedge extRstN) begin
    if (!extRstN) begin
      stretchCnt  <= '0;
      stretchDone <= 1'b0;
    end else if (syncQ[SYNC_STAGES-1] && !stretchDone) begin
      stretchCnt <= stretchCnt + 1'b1;
      if (stretchCnt == CNT_LAST) stretchDone <= 1'b1;
    end
  end

  always_comb begin
    strb.capture = ~syncQ[0];
    strb.syncRel = syncQ[SYNC_STAGES-1];
    strb.inRst   = ~stretchDone;
  end

  assign intRstN = stretchDone;

endmodule

// File: rtl/rsb_dp.sv
module rsb_dp
  import rsb_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int CORE_DIV        = 8,
  parameter int CLK_VALID_TICKS = 6,
  parameter int NUM_SER         = 2
) (
  input  logic               clkIn,
  input  logic               arstN,
  input  rsbStrobe_t         strb,
  input  logic [DATA_W-1:0]  hostData,
  input  logic               bypassClr,
  output logic               coreClkEn,
  output logic [BOOT_W-1:0]  bootCfg,
  output logic               pllBypass,
  output logic               clkZOe,
  output logic               clkLowHold,
  output logic               memBusOe,
  output logic [NUM_SER-1:0] serialOe,
  output logic               busReqValid
);

  localparam int DIV_W  = $clog2(CORE_DIV);
  localparam int TICK_W = $clog2(CLK_VALID_TICKS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CORE_DIV - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLK_VALID_TICKS - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic              clkValid;
  logic [BOOT_W-1:0] strapSel;
  logic              unusedBus;

  // Core clock enable: 1-in-CORE_DIV during reset, every cycle after
  always_ff @(posedge clkIn or negedge arstN) begin
    if (!arstN) divCnt <= '0;
    else        divCnt <= divCnt + 1'b1;
  end

  assign coreClkEn = strb.inRst ? (divCnt == DIV_LAST) : 1'b1;

  // Clock outputs become valid after a number of slow core periods
  always_ff @(posedge clkIn or negedge arstN) begin
    if (!arstN) begin
      tickCnt  <= '0;
      clkValid <= 1'b0;
    end else if (strb.syncRel && coreClkEn && !clkValid) begin
      tickCnt <= tickCnt + 1'b1;
      if (tickCnt == TICK_LAST) clkValid <= 1'b1;
    end
  end

  // Strap selection from the host bus
  for (genvar i = 0; i < BOOT_W; i++) begin : g_strap
    assign strapSel[i] = hostData[bootPos(i)];
  end
  assign unusedBus = ^hostData;

  always_ff @(posedge clkIn or negedge arstN) begin
    if (!arstN)            bootCfg <= '0;
    else if (strb.capture) bootCfg <= strapSel;
  end

  // Bypass select: set by reset, cleared only from run mode
  always_ff @(posedge clkIn or negedge arstN) begin
    if (!arstN)                          pllBypass <= 1'b1;
    else if (bypassClr && !strb.inRst)   pllBypass <= 1'b0;
  end

  // Pin-group controls
  assign clkZOe      = clkValid;
  assign clkLowHold  = ~clkValid;
  assign memBusOe    = ~strb.inRst;
  assign busReqValid = ~strb.inRst;

  for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
    assign serialOe[g] = ~strb.inRst;
  end

endmodule

// File: rtl/rsb_top.sv
module rsb_top
  import rsb_pkg::*;
#(
  parameter int STRETCH         = 512,
  parameter int SYNC_STAGES     = 2,
  parameter int CORE_DIV        = 8,
  parameter int CLK_VALID_TICKS = 6,
  parameter int DATA_W          = 16,
  parameter int NUM_SER         = 2
) (
  input  logic               clkIn,
  input  logic               extRstN,
  input  logic [DATA_W-1:0]  hostData,
  input  logic               bypassClr,
  output logic               intRstN,
  output logic               coreClkEn,
  output logic [BOOT_W-1:0]  bootCfg,
  output logic               pllBypass,
  output logic               clkZOe,
  output logic               clkLowHold,
  output logic               memBusOe,
  output logic [NUM_SER-1:0] serialOe,
  output logic               busReqValid
);

  rsbStrobe_t strb;

  rsb_ctrl #(
    .STRETCH    (STRETCH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clkIn  (clkIn),
    .extRstN(extRstN),
    .strb   (strb),
    .intRstN(intRstN)
  );

  rsb_dp #(
    .DATA_W         (DATA_W),
    .CORE_DIV       (CORE_DIV),
    .CLK_VALID_TICKS(CLK_VALID_TICKS),
    .NUM_SER        (NUM_SER)
  ) u_dp (
    .clkIn      (clkIn),
    .arstN      (extRstN),
    .strb       (strb),
    .hostData   (hostData),
    .bypassClr  (bypassClr),
    .coreClkEn  (coreClkEn),
    .bootCfg    (bootCfg),
    .pllBypass  (pllBypass),
    .clkZOe     (clkZOe),
    .clkLowHold (clkLowHold),
    .memBusOe   (memBusOe),
    .serialOe   (serialOe),
    .busReqValid(busReqValid)
  );

endmodule

// File: rtl/rsb_chk.sv
module rsb_chk #(
  parameter int NUM_SER = 2
) (
  input logic               clkIn,
  input logic               extRstN,
  input logic               intRstN,
  input logic               coreClkEn,
  input logic [3:0]         bootCfg,
  input logic               pllBypass,
  input logic               clkZOe,
  input logic               clkLowHold,
  input logic               memBusOe,
  input logic [NUM_SER-1:0] serialOe,
  input logic               busReqValid
);

  // R1
  release_after_pin_high_chk: assert property (@(posedge clkIn) disable iff (!extRstN)
    $rose(intRstN) |-> $past(extRstN));

  // R2
  slow_enable_isolated_chk: assert property (@(posedge clkIn) disable iff (!extRstN)
    (!intRstN && coreClkEn) |=> (!coreClkEn || intRstN));

  // R3
  straps_frozen_chk: assert property (@(posedge clkIn) disable iff (!extRstN)
    (intRstN && $past(intRstN)) |-> $stable(bootCfg));

  // R5
  clocks_valid_before_run_chk: assert property (@(posedge clkIn) disable iff (!extRstN)
    intRstN |-> (clkZOe && !clkLowHold));

  // R6
  groups_on_in_run_chk: assert property (@(posedge clkIn) disable iff (!extRstN)
    intRstN |-> (memBusOe && busReqValid && (&serialOe)));

  // R7
  bypass_in_reset_chk: assert property (@(posedge clkIn) disable iff (!extRstN)
    !intRstN |-> pllBypass);

endmodule

bind rsb_top rsb_chk #(.NUM_SER(NUM_SER)) u_chk (
  .clkIn      (clkIn),
  .extRstN    (extRstN),
  .intRstN    (intRstN),
  .coreClkEn  (coreClkEn),
  .bootCfg    (bootCfg),
  .pllBypass  (pllBypass),
  .clkZOe     (clkZOe),
  .clkLowHold (clkLowHold),
  .memBusOe   (memBusOe),
  .serialOe   (serialOe),
  .busReqValid(busReqValid)
);

// File: tb/tb_rsb_top.sv
`timescale 1ns/1ps
module tb_rsb_top;

  localparam int STRETCH = 512;
  localparam int SYNC    = 2;
  localparam int DIV     = 8;
  localparam int VT      = 6;

  logic        clkIn = 1'b0;
  logic        extRstN;
  logic [15:0] hostData;
  logic        bypassClr;
  logic        intRstN, coreClkEn, pllBypass, clkZOe, clkLowHold;
  logic        memBusOe, busReqValid;
  logic [3:0]  bootCfg;
  logic [1:0]  serialOe;

  int nChk = 0;
  int nBad = 0;

  always #2 clkIn = ~clkIn;

  rsb_top dut (
    .clkIn(clkIn), .extRstN(extRstN), .hostData(hostData), .bypassClr(bypassClr),
    .intRstN(intRstN), .coreClkEn(coreClkEn), .bootCfg(bootCfg), .pllBypass(pllBypass),
    .clkZOe(clkZOe), .clkLowHold(clkLowHold), .memBusOe(memBusOe),
    .serialOe(serialOe), .busReqValid(busReqValid)
  );

  function automatic logic [3:0] expBoot(input logic [15:0] d);
    return {d[14], d[8], d[4], d[3]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clkIn);
  endtask

  task automatic checkResetPins(input string req);
    chk({req, " intRstN"}, intRstN, 0);
    chk({req, " clkZOe"}, clkZOe, 0);
    chk({req, " clkLowHold"}, clkLowHold, 1);
    chk({req, " groups"}, {memBusOe, serialOe, busReqValid}, 0);
    chk({req, " pllBypass"}, pllBypass, 1);
  endtask

  task automatic fullRun(input logic [15:0] d);
    int tickBad = 0;
    hostData = d;
    step(1);
    extRstN = 1'b1;
    for (int k = 1; k <= SYNC + STRETCH + 4; k++) begin
      step(1);
      if (k == 3) hostData = 16'($urandom);
      if (k <= 8 * DIV && coreClkEn !== ((k % DIV) == DIV - 1)) tickBad++;
      if (k > SYNC + STRETCH && coreClkEn !== 1'b1) tickBad++;
      if (k == 1) chk("R3 capture at first edge", bootCfg, expBoot(d));
      if (k == VT * DIV - 1) begin
        chk("R5 clocks still floating", clkZOe, 0);
        chk("R5 third clock still low", clkLowHold, 1);
      end
      if (k == VT * DIV) begin
        chk("R5 clocks valid", clkZOe, 1);
        chk("R5 third clock released", clkLowHold, 0);
      end
      if (k == SYNC + STRETCH - 1) begin
        chk("R1 still in reset", intRstN, 0);
        chk("R6 groups held off", {memBusOe, serialOe, busReqValid}, 0);
      end
      if (k == SYNC + STRETCH) begin
        chk("R1 released", intRstN, 1);
        chk("R6 groups enabled", {memBusOe, serialOe, busReqValid}, 4'hF);
        chk("R7 bypass after release", pllBypass, 1);
      end
    end
    chk("R2 core enable pattern", tickBad, 0);
    chk("R3 later bus changes ignored", bootCfg, expBoot(d));
  endtask

  task automatic assertAsync();
    extRstN = 1'b0;
    #1;
    checkResetPins("R9 async assert");
    chk("R4 straps cleared in reset", bootCfg, 0);
    step(2);
  endtask

  task automatic abortRun(input logic [15:0] d, input int n);
    hostData = d;
    step(1);
    extRstN = 1'b1;
    step(n);
    chk("R8 still stretching before abort", intRstN, 0);
    extRstN = 1'b0;
    #1;
    chk("R9 abort forces reset", {intRstN, clkZOe, clkLowHold}, 3'b001);
    step(3);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    extRstN   = 1'b0;
    hostData  = 16'h0;
    bypassClr = 1'b0;
    step(4);
    checkResetPins("R6 reset state");
    chk("R4 straps zero at start", bootCfg, 0);
    chk("R2 enable held while pin low", coreClkEn, 0);
    bypassClr = 1'b1;
    step(2);
    chk("R7 clear ignored in reset", pllBypass, 1);
    bypassClr = 1'b0;

    fullRun(16'h4118);
    bypassClr = 1'b1;
    step(1);
    bypassClr = 1'b0;
    chk("R7 cleared by request", pllBypass, 0);
    step(2);
    chk("R7 stays cleared", pllBypass, 0);
    assertAsync();

    fullRun(16'hBEE7);
    assertAsync();

    abortRun(16'h4118, 100);
    fullRun(16'h0008);
    chk("R8 recapture after early abort", bootCfg, 4'h1);
    assertAsync();

    abortRun(16'hFFFF, SYNC + STRETCH - 1);
    fullRun(16'h4000);
    chk("R8 recapture after last-cycle abort", bootCfg, 4'h8);
    assertAsync();

    for (int it = 0; it < 6; it++) begin
      d = 16'($urandom);
      if ($urandom % 2 == 1) abortRun(16'($urandom), 3 + int'($urandom % 500));
      fullRun(d);
      chk("R8 R3 random run straps", bootCfg, expBoot(d));
      if ($urandom % 2 == 1) begin
        bypassClr = 1'b1;
        step(1);
        bypassClr = 1'b0;
        chk("R7 random clear", pllBypass, 0);
      end
      assertAsync();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChk++;
    nBad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule